// File: doc/BRIEF.md
# Multicarrier Sinusoidal PWM Modulator for a Five-Level Bridge Leg

This block produces the switching pattern for one phase leg built from two cascaded full-bridge cells, which together give five output levels. A signed sinusoidal reference is built inside the block from a free-running phase accumulator and is scaled by a modulation index. Four triangular carriers run from the same accumulator. Each carrier is compared with the reference, and the number of carriers the reference lies above sets the leg level in the range −2..+2.

The carrier arrangement is chosen at run time. Four arrangements stack the carriers in separate vertical bands: all in phase; upper pair opposed to lower pair; alternately opposed; or stepped by quarter periods. A fifth arrangement gives every carrier the full range and offsets successive carriers by a quarter period. The carrier frequency is an odd multiple of the reference frequency, picked from four ratios. Changes to the arrangement or the ratio take effect only when a reference period starts. Each of the four bridge legs has a complementary pair of switches. The block drives each pair with a dead time in clock cycles that software sets.

Top module: `mcpwm_mod`

## Requirements
- R1: During reset and until the first comparison, cmp_o = 4'b0011, level_o = 0, every gate_hi_o bit is 0 and every gate_lo_o bit is 1.
- R2: The phase register stays at 0 for the first clock edge after reset is released, then gains REF_INC (mod 2^ACC_W) on every edge. The reference is ref = ±((u·(32768−u))>>13, clamped to 32767)·mi>>15, where u = phase[ACC_W−2 -: 15] and the sign is negative when the top phase bit is 1.
- R3: The carrier phase is (phase·mf) mod 2^ACC_W plus the carrier's shift in quarter periods (k·2^(ACC_W−2)), with mf = 21, 27, 33, 39 for mf_sel_i = 0..3. The triangle is t = p[13:0] when p[14]=0 and ~p[13:0] otherwise, where p is the top 15 bits of the carrier phase.
- R4: Mode code 0: carrier j (j=0 bottom) = −32768 + 16384·j + t, and all shifts are 0.
- R5: Mode code 1: carriers are stacked as in R4, carriers 0 and 1 are shifted by two quarters and carriers 2 and 3 by none.
- R6: Mode code 2: carriers are stacked as in R4, odd-numbered carriers are shifted by two quarters and even-numbered carriers by none.
- R7: Mode code 3: carriers are stacked as in R4, and carrier j is shifted by j quarters.
- R8: Mode code 4: carrier j = −32768 + 4·t over the full range, and carrier j is shifted by j quarters.
- R9: cmp_o[j] is registered and equals (ref > carrier j), computed from the phase and configuration before the edge. Mode codes 5..7 behave as code 0.
- R10: level_o = (number of set cmp_o bits) − 2.
- R11: The leg targets follow a fixed table. Gate index 2c is cell c leg A and 2c+1 is cell c leg B. Level +2 gives both cells +1, +1 gives cell 0 +1, 0 gives both cells 0, −1 gives cell 0 −1, −2 gives both −1. A cell at +1 raises leg A, at −1 raises leg B, and at 0 raises neither.
- R12: Each leg target passes through a register on the edge after level_o shows it. When a target changes, both gates of that leg are 0 for exactly dead_i cycles, and then the new high or low gate turns on. The high and low gates of a leg are never 1 together.
- R13: mode_i and mf_sel_i are sampled only on the first edge after reset and on the edge where the phase wraps. At any other time they have no effect.
- R14: A mod_idx_i value above 32768 acts as 32768, and a value of 0 makes ref = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Carrier arrangement code |
| mf_sel_i | input | 2 | Frequency ratio select |
| mod_idx_i | input | 16 | Modulation index, Q1.15 |
| dead_i | input | DT_W | Dead time in clock cycles |
| cmp_o | output | 4 | Per-carrier comparison bits |
| gate_hi_o | output | 4 | Upper switch gates, one per leg |
| gate_lo_o | output | 4 | Lower switch gates, one per leg |
| level_o | output | 3 | Signed leg level, −2..+2 |

## Verification
The bench builds the block with ACC_W = 16 and REF_INC = 64. This makes a reference period 1024 cycles long, so every arrangement and every frequency ratio runs through complete periods, including the wrap where new settings are taken. Sixteen phase bits are the minimum the reference formula allows, so the carrier phase product wraps many times per period. This exercises the modular carrier arithmetic and the quarter-period shifts at their coarsest. Settings changed in the middle of a period, indices above full scale and dead times from zero upward are all applied against a cycle-exact model.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  localparam int N_CAR  = 4;
  localparam int BAND_W = 14;
  localparam int REF_W  = 17;

  typedef enum logic [2:0] {
    MODE_PD   = 3'd0,
    MODE_POD  = 3'd1,
    MODE_APOD = 3'd2,
    MODE_VS90 = 3'd3,
    MODE_HS   = 3'd4
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic [1:0] mf_sel;
  } cfg_t;

  function automatic logic [5:0] mf_of(logic [1:0] sel);
    return 6'd21 + 6'd6 * {4'd0, sel};
  endfunction

  function automatic mode_e mode_norm(logic [2:0] code);
    return (code > 3'd4) ? MODE_PD : mode_e'(code);
  endfunction
endpackage

// File: rtl/mcpwm_phase.sv
module mcpwm_phase
  import mcpwm_pkg::*;
#(
  parameter int          ACC_W   = 32,
  parameter int unsigned REF_INC = 2147
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       mf_sel_i,
  output logic             run_o,
  output logic [ACC_W-1:0] phase_o,
  output cfg_t             cfg_o
);
  localparam logic [ACC_W:0] INC_EXT = (ACC_W+1)'(REF_INC);

  logic [ACC_W:0] sum;
  cfg_t           cfg_new;

  assign sum     = {1'b0, phase_o} + INC_EXT;
  assign cfg_new = '{mode: mode_norm(mode_i), mf_sel: mf_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      phase_o <= '0;
      cfg_o   <= '{mode: MODE_PD, mf_sel: 2'd0};
    end else if (!run_o) begin
      run_o <= 1'b1;
      cfg_o <= cfg_new;
    end else begin
      phase_o <= sum[ACC_W-1:0];
      if (sum[ACC_W]) cfg_o <= cfg_new;
    end
  end

  // R13: settings move only on a period start
  a_r13_cfg_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> (phase_o < ACC_W'(REF_INC)));
endmodule

// File: rtl/mcpwm_ref.sv
module mcpwm_ref
  import mcpwm_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0]        phase_i,
  input  logic [15:0]             mod_idx_i,
  output logic signed [REF_W-1:0] ref_o
);
  logic [14:0] u;
  logic [15:0] cu;
  logic [31:0] prod;
  logic [18:0] mag_raw;
  logic [14:0] mag;
  logic [15:0] mi_c;
  logic [31:0] sp;
  logic [14:0] scaled;

  always_comb begin
    u       = phase_i[ACC_W-2 -: 15];
    cu      = 16'd32768 - {1'b0, u};
    prod    = {17'd0, u} * {16'd0, cu};
    mag_raw = prod[31:13];
    mag     = (mag_raw > 19'd32767) ? 15'h7fff : mag_raw[14:0];
    mi_c    = (mod_idx_i > 16'h8000) ? 16'h8000 : mod_idx_i;
    sp      = {17'd0, mag} * {16'd0, mi_c};
    scaled  = sp[29:15];
    ref_o   = phase_i[ACC_W-1] ? -$signed({2'b00, scaled}) : $signed({2'b00, scaled});
  end
endmodule

// File: rtl/mcpwm_carrier_bank.sv
module mcpwm_carrier_bank
  import mcpwm_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic [ACC_W-1:0]        phase_i,
  input  cfg_t                    cfg_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [N_CAR-1:0]        cmp_o
);
  localparam int CW = REF_W + 1;

  logic [ACC_W-1:0]     cbase;
  logic [N_CAR-1:0]     hit;
  logic signed [CW-1:0] ref_x;

  assign cbase = phase_i * ACC_W'(mf_of(cfg_i.mf_sel));
  assign ref_x = CW'(ref_i);

  for (genvar j = 0; j < N_CAR; j++) begin : g_car
    localparam logic signed [CW-1:0] LOW = CW'(-32768 + j * (1 << BAND_W));
    logic [1:0]           quarter;
    logic [ACC_W-1:0]     cp;
    logic [BAND_W:0]      p;
    logic [BAND_W-1:0]    t;
    logic signed [CW-1:0] car;

    always_comb begin
      case (cfg_i.mode)
        MODE_POD:           quarter = (j < N_CAR / 2) ? 2'd2 : 2'd0;
        MODE_APOD:          quarter = (j % 2 == 1) ? 2'd2 : 2'd0;
        MODE_VS90, MODE_HS: quarter = 2'(j);
        default:            quarter = 2'd0;
      endcase
      cp = cbase + {quarter, {(ACC_W-2){1'b0}}};
      p  = cp[ACC_W-1 -: BAND_W+1];
      t  = p[BAND_W] ? ~p[BAND_W-1:0] : p[BAND_W-1:0];
      if (cfg_i.mode == MODE_HS)
        car = CW'(-32768) + $signed({2'b00, t, 2'b00});
      else
        car = LOW + $signed({{(CW-BAND_W){1'b0}}, t});
      hit[j] = ref_x > car;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_o <= 4'b0011;
    else if (run_i)  cmp_o <= hit;
  end

  // R4: stacked bands give a thermometer code
  a_r4_stacked_thermo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_i.mode) != MODE_HS) |->
      ((!cmp_o[1] || cmp_o[0]) && (!cmp_o[2] || cmp_o[1]) && (!cmp_o[3] || cmp_o[2])));
endmodule

// File: rtl/mcpwm_deadtime.sv
module mcpwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            des_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            cur_q;
  logic [DT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= 1'b0;
      cnt_q <= '0;
    end else if (des_i != cur_q) begin
      cur_q <= des_i;
      cnt_q <= dead_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign hi_o = cur_q && (cnt_q == '0);
  assign lo_o = !cur_q && (cnt_q == '0);

  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));
  a_r12_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((des_i != cur_q) && (dead_i != '0)) |=> (!hi_o && !lo_o));
endmodule

// File: rtl/mcpwm_mod.sv
module mcpwm_mod
  import mcpwm_pkg::*;
#(
  parameter int          ACC_W   = 32,
  parameter int unsigned REF_INC = 2147,
  parameter int          DT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        mf_sel_i,
  input  logic [15:0]       mod_idx_i,
  input  logic [DT_W-1:0]   dead_i,
  output logic [3:0]        cmp_o,
  output logic [3:0]        gate_hi_o,
  output logic [3:0]        gate_lo_o,
  output logic signed [2:0] level_o
);
  logic                    run;
  logic [ACC_W-1:0]        phase;
  cfg_t                    cfg;
  logic signed [REF_W-1:0] ref_v;
  logic [3:0]              leg_des;

  mcpwm_phase #(.ACC_W(ACC_W), .REF_INC(REF_INC)) u_phase (
    .clk_i, .rst_ni, .mode_i, .mf_sel_i,
    .run_o(run), .phase_o(phase), .cfg_o(cfg)
  );

  mcpwm_ref #(.ACC_W(ACC_W)) u_ref (
    .phase_i(phase), .mod_idx_i, .ref_o(ref_v)
  );

  mcpwm_carrier_bank #(.ACC_W(ACC_W)) u_bank (
    .clk_i, .rst_ni, .run_i(run), .phase_i(phase), .cfg_i(cfg),
    .ref_i(ref_v), .cmp_o
  );

  assign level_o = 3'($countones(cmp_o)) - 3'sd2;

  // leg order {cell1 B, cell1 A, cell0 B, cell0 A}
  always_comb begin
    case (level_o)
      3'sd2:   leg_des = 4'b0101;
      3'sd1:   leg_des = 4'b0001;
      -3'sd1:  leg_des = 4'b0010;
      -3'sd2:  leg_des = 4'b1010;
      default: leg_des = 4'b0000;
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : g_leg
    mcpwm_deadtime #(.DT_W(DT_W)) u_dt (
      .clk_i, .rst_ni, .des_i(leg_des[g]), .dead_i,
      .hi_o(gate_hi_o[g]), .lo_o(gate_lo_o[g])
    );
  end

  // R11: a cell never raises both of its legs
  a_r11_cell_legs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hi_o[0] && gate_hi_o[1]) && !(gate_hi_o[2] && gate_hi_o[3]));
endmodule

// File: tb/sim_mcpwm_mod.sv
module sim_mcpwm_mod;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int INC   = 64;
  localparam int DT_W  = 8;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [2:0]      mode = 0;
  logic [1:0]      mf_sel = 0;
  logic [15:0]     mi = 16'h8000;
  logic [DT_W-1:0] dead = 0;
  logic [3:0]      cmp_o, gate_hi_o, gate_lo_o;
  logic signed [2:0] level_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mcpwm_mod #(.ACC_W(W), .REF_INC(INC), .DT_W(DT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .mf_sel_i(mf_sel),
    .mod_idx_i(mi), .dead_i(dead), .cmp_o, .gate_hi_o, .gate_lo_o, .level_o
  );

  function automatic int norm(int m); return (m > 4) ? 0 : m; endfunction
  function automatic int mf_val(int s); return 21 + 6 * s; endfunction

  function automatic int ref_of(int acc, int idx);
    int u, mag, mic, s;
    u   = acc & 32767;
    mag = (u * (32768 - u)) >> 13;
    if (mag > 32767) mag = 32767;
    mic = (idx > 32768) ? 32768 : idx;
    s   = (mag * mic) >> 15;
    return ((acc >> 15) & 1) ? -s : s;
  endfunction

  function automatic int car_of(int j, int acc, int md, int ms);
    int k, cp, p, t;
    case (md)
      1: k = (j < 2) ? 2 : 0;
      2: k = (j % 2) ? 2 : 0;
      3, 4: k = j;
      default: k = 0;
    endcase
    cp = ((acc * mf_val(ms)) + k * 16384) & 65535;
    p  = cp >> 1;
    t  = (p & 16384) ? (~p & 16383) : (p & 16383);
    return (md == 4) ? (-32768 + 4 * t) : (-32768 + j * 16384 + t);
  endfunction

  function automatic logic [3:0] legs_of(logic [3:0] c);
    int lv, c0, c1;
    logic [3:0] r;
    lv = $countones(c) - 2;
    c0 = (lv > 0) ? 1 : (lv < 0) ? -1 : 0;
    c1 = (lv == 2) ? 1 : (lv == -2) ? -1 : 0;
    r[0] = (c0 == 1);  r[1] = (c0 == -1);
    r[2] = (c1 == 1);  r[3] = (c1 == -1);
    return r;
  endfunction

  function automatic string mode_tag(int m);
    case (m) 1: return "R5"; 2: return "R6"; 3: return "R7"; 4: return "R8"; default: return "R4"; endcase
  endfunction

  // cycle-level model built from the requirements
  bit         m_run, m_r13, m_big;
  int         m_acc, m_mode, m_mf, m_cmode;
  logic [3:0] m_cmp, m_cur;
  int         m_cnt [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_acc <= 0; m_mode <= 0; m_mf <= 0; m_cmode <= 0;
      m_cmp <= 4'b0011; m_cur <= 4'b0; m_r13 <= 0; m_big <= 0;
      for (int g = 0; g < 4; g++) m_cnt[g] <= 0;
    end else begin
      logic [3:0] nc, des;
      if (!m_run) begin
        m_run <= 1; m_mode <= norm(mode); m_mf <= mf_sel;
      end else begin
        m_acc <= (m_acc + INC) & 65535;
        if (m_acc + INC > 65535) begin m_mode <= norm(mode); m_mf <= mf_sel; end
        for (int j = 0; j < 4; j++) nc[j] = ref_of(m_acc, mi) > car_of(j, m_acc, m_mode, m_mf);
        m_cmp   <= nc;
        m_cmode <= m_mode;
        m_r13   <= (norm(mode) != m_mode) || (mf_sel != m_mf);
        m_big   <= (mi > 16'h8000);
      end
      des = legs_of(m_cmp);
      for (int g = 0; g < 4; g++) begin
        if (des[g] != m_cur[g]) begin m_cur[g] <= des[g]; m_cnt[g] <= dead; end
        else if (m_cnt[g] != 0) m_cnt[g] <= m_cnt[g] - 1;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_cycle();
    logic [3:0] ehi, elo;
    string tag;
    bit blank;
    tag = {"R2/R3/R9/", mode_tag(m_cmode), m_r13 ? "/R13" : "", m_big ? "/R14" : ""};
    chk(cmp_o === m_cmp, tag, cmp_o, m_cmp);
    chk(level_o === 3'($countones(m_cmp) - 2), "R10", level_o, $countones(m_cmp) - 2);
    blank = 0;
    for (int g = 0; g < 4; g++) begin
      ehi[g] = m_cur[g] && (m_cnt[g] == 0);
      elo[g] = !m_cur[g] && (m_cnt[g] == 0);
      if (m_cnt[g] != 0) blank = 1;
    end
    chk({gate_hi_o, gate_lo_o} === {ehi, elo}, blank ? "R12" : "R11",
        {gate_hi_o, gate_lo_o}, {ehi, elo});
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmp_o === 4'b0011, "R1", cmp_o, 3);
    chk(level_o === 3'sd0, "R1", level_o, 0);
    chk({gate_hi_o, gate_lo_o} === 8'h0f, "R1", {gate_hi_o, gate_lo_o}, 8'h0f);
    rst_n = 1;
    @(negedge clk);
    chk(cmp_o === 4'b0011, "R1", cmp_o, 3);
    for (int seg = 0; seg < 14; seg++) begin
      int sw;
      sw = 200 + ($urandom % 600);
      for (int cyc = 0; cyc < 1536; cyc++) begin
        @(negedge clk);
        check_cycle();
        if (seg == 6 && cyc >= 1100) chk(level_o === 3'sd0, "R14", level_o, 0);
        if (cyc == sw || (seg == 0 && cyc == 0)) begin
          mode   = 3'(seg % 6);
          mf_sel = 2'($urandom % 4);
          dead   = DT_W'($urandom % 4);
          if (seg == 6) mode = 3'd0;
        end
        if (seg == 6 && cyc == 0) mi = 16'd0;
        else if (seg == 3 && cyc == 0) mi = 16'hffff;
        else if (seg == 0 && cyc == 0) mi = 16'h8000;
        else if (seg != 6 && seg != 3 && seg != 0 && (cyc % 256) == 0)
          mi = 16'($urandom);
        if (seg == 5 && cyc == sw) dead = '0;
      end
      if (seg == 6) begin
        repeat (1100) begin @(negedge clk); check_cycle(); end
      end
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule